// File: doc/BRIEF.md
# Packet-Boundary Source Switch

This block picks one of four 64-bit data streams and passes it to a single output. Each stream carries eight byte lanes with one control flag per lane. The source is chosen by a 2-bit code, taken either from a register field or from two select pins. In normal mode the block never cuts a frame. When the selection changes, it keeps passing the old source until that source's frame ends. It then sends idle words until the newly chosen source begins a frame, and only then passes the new source.

A force field can bypass this logic. It drives the four source enables directly and takes effect on the next word. A status register gives a sticky done flag and the active enables; reading it clears the flag. A data-path reset or a local fault puts the selection back to the default source. Neither event touches the force field.

Top module: `pktsw_top`

## Requirements
- R1: After reset, out_ctrl is 8'hFF, out_data is eight 8'h07 lanes, src_en is 4'b0001, and the control register (address 0) reads 16'h1000 (pin select on, code 00). The status register (address 2) reads 16'h1000 (active 0001, done 0). A read is requested with reg_rd and its data is valid on reg_rdata in the following cycle.
- R2: Source code k (00 own low-speed, 01 own high-speed, 10 other channel low-speed, 11 other channel high-speed) enables src_en bit k and forwards input word k. Control bit 12 = 1 takes the code from sel_pins; bit 12 = 0 takes it from control bits 15:14. Outside force mode, exactly one bit of src_en is set.
- R3: After a new code is selected while the current source is inside a frame, the current source's words keep being forwarded, up to and including the word that holds a terminate character (8'hFD with its lane's control bit set, in any lane).
- R4: Between the old frame and the new one, the output is the idle word (all lanes 8'h07, out_ctrl 8'hFF), and src_en keeps showing the old source. The first new-source word with 8'hFB in lane 0 and control bit 0 set is forwarded, and src_en moves to the new source on that same word.
- R5: If the current source is between frames when a new code is seen, idle output starts with the very next word processed.
- R6: A new code that arrives while a switch is pending replaces the pending target. The done flag stays 0 until a switch completes.
- R7: Force field (address 1, bits 4:0): when bit 4 = 1, src_en equals bits 3:0 from the next word on, with no frame wait. The output is the lowest-indexed enabled source, or idle when bits 3:0 are zero. When bit 4 = 0, the normal logic drives src_en.
- R8: Status bit 10 is set when a switch completes, and status bits 15:12 show src_en. A status read returns the flag and clears it. A completion in the same cycle as the read wins over the clear.
- R9: A dp_reset or local_fault cycle sets control bits 15:14 to 00 and outputs idle with src_en 0001 for that word. It then waits for a frame start on the selected source. The force field and the force-mode output are unchanged.
- R10: Every output word and src_en value appears one clock after its input word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data | input | 256 | Four 64-bit source words, source k in bits 64k+63:64k |
| src_ctrl | input | 32 | Four 8-bit lane control masks, source k in bits 8k+7:8k |
| sel_pins | input | 2 | Pin source code, used when control bit 12 is 1 |
| dp_reset | input | 1 | Data-path reset pulse |
| local_fault | input | 1 | Local fault indication, acts in every cycle it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 force, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after reg_rd |
| out_data | output | 64 | Forwarded or idle data word |
| out_ctrl | output | 8 | Lane control mask of the output word |
| src_en | output | 4 | Source enables applied to the output word |

## Verification
An input word presented at a falling edge passes through one register, so its output word and src_en value are sampled at the next falling edge. The bench checks every cycle against a cycle-stepped model of the frame rules. Register writes and fault pulses act on the edge that follows them, so the model applies them after working out that cycle's word. Read data is due one cycle after the strobe. The model captures the expected value, including the done flag from before the clearing edge, and compares it on the next sample.

// File: rtl/pktsw_pkg.sv
package pktsw_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int CTRL_W = LANES;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int REG_W  = 16;

  localparam logic [LANE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [LANE_W-1:0] CH_START = 8'hFB;
  localparam logic [LANE_W-1:0] CH_TERM  = 8'hFD;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_FORCE = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  typedef enum logic {ST_FWD, ST_GAP} sw_state_e;

  function automatic logic [DATA_W-1:0] idle_data();
    return {LANES{CH_IDLE}};
  endfunction

  function automatic logic word_is_start(logic [DATA_W-1:0] d, logic [CTRL_W-1:0] c);
    return c[0] && (d[LANE_W-1:0] == CH_START);
  endfunction

  function automatic logic word_has_term(logic [DATA_W-1:0] d, logic [CTRL_W-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (c[i] && (d[i*LANE_W +: LANE_W] == CH_TERM)) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [NSRC-1:0] code_to_en(logic [SEL_W-1:0] code);
    return {{(NSRC-1){1'b0}}, 1'b1} << code;
  endfunction

  // {valid, index} of the lowest set enable
  function automatic logic [SEL_W:0] lowest_en(logic [NSRC-1:0] en);
    logic [SEL_W:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (en[i]) r = {1'b1, SEL_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pktsw_frame_det.sv
module pktsw_frame_det
  import pktsw_pkg::*;
(
  input  logic [NSRC*DATA_W-1:0] src_data,
  input  logic [NSRC*CTRL_W-1:0] src_ctrl,
  output logic [NSRC-1:0]        sof,
  output logic [NSRC-1:0]        eof
);
  for (genvar s = 0; s < NSRC; s++) begin : g_det
    assign sof[s] = word_is_start(src_data[s*DATA_W +: DATA_W], src_ctrl[s*CTRL_W +: CTRL_W]);
    assign eof[s] = word_has_term(src_data[s*DATA_W +: DATA_W], src_ctrl[s*CTRL_W +: CTRL_W]);
  end
endmodule

// File: rtl/pktsw_smart.sv
module pktsw_smart
  import pktsw_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEF_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] req,
  input  logic [NSRC-1:0]  sof,
  input  logic [NSRC-1:0]  eof,
  input  logic             path_evt,
  output logic [SEL_W-1:0] fwd_idx,
  output logic             emit_idle,
  output logic             commit
);
  sw_state_e        st_q, st_d;
  logic [SEL_W-1:0] act_q, act_d;
  logic             open_q, open_d;
  logic             mism, gap_now;

  assign mism    = (act_q != req);
  assign gap_now = (st_q == ST_GAP) || (mism && !open_q);

  always_comb begin
    st_d      = st_q;
    act_d     = act_q;
    open_d    = open_q;
    fwd_idx   = act_q;
    emit_idle = 1'b0;
    commit    = 1'b0;
    if (path_evt) begin
      emit_idle = 1'b1;
      fwd_idx   = DEF_SEL;
      st_d      = ST_GAP;
      act_d     = DEF_SEL;
      open_d    = 1'b0;
    end else if (gap_now) begin
      if (sof[req]) begin
        commit  = 1'b1;
        fwd_idx = req;
        act_d   = req;
        st_d    = ST_FWD;
        open_d  = !eof[req];
      end else begin
        emit_idle = 1'b1;
        st_d      = ST_GAP;
      end
    end else begin
      if (eof[act_q]) begin
        open_d = 1'b0;
        if (mism) st_d = ST_GAP;
      end else if (sof[act_q]) begin
        open_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_GAP;
      act_q  <= DEF_SEL;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      open_q <= open_d;
    end
  end
endmodule

// File: rtl/pktsw_regs.sv
module pktsw_regs
  import pktsw_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEF_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             path_evt,
  input  logic             commit,
  input  logic [NSRC-1:0]  en_now,
  output logic [REG_W-1:0] reg_rdata,
  output logic [SEL_W-1:0] reg_sel,
  output logic             pin_mode,
  output logic [NSRC:0]    force_fld,
  output logic             status_done
);
  logic [REG_W-1:0] ctrl_q, force_q, rd_mux;
  logic             stat_rd;

  assign stat_rd     = reg_rd && (reg_addr == A_STAT);
  assign reg_sel     = ctrl_q[15:14];
  assign pin_mode    = ctrl_q[12];
  assign force_fld   = force_q[NSRC:0];

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_FORCE: rd_mux = force_q;
      A_STAT:  rd_mux = {en_now, 1'b0, status_done, 10'h000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= {DEF_SEL, 1'b0, 1'b1, 12'h000};
      force_q     <= '0;
      status_done <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      if (path_evt)                          ctrl_q[15:14] <= DEF_SEL;
      else if (reg_wr && reg_addr == A_CTRL) ctrl_q        <= reg_wdata;
      if (reg_wr && reg_addr == A_FORCE) force_q <= reg_wdata;
      status_done <= commit | (status_done & ~stat_rd);
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pktsw_top.sv
module pktsw_top
  import pktsw_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEF_SEL = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC*DATA_W-1:0] src_data,
  input  logic [NSRC*CTRL_W-1:0] src_ctrl,
  input  logic [SEL_W-1:0]       sel_pins,
  input  logic                   dp_reset,
  input  logic                   local_fault,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [1:0]             reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic [DATA_W-1:0]      out_data,
  output logic [CTRL_W-1:0]      out_ctrl,
  output logic [NSRC-1:0]        src_en
);
  logic [DATA_W-1:0] w_data [NSRC];
  logic [CTRL_W-1:0] w_ctrl [NSRC];
  logic [NSRC-1:0]   sof, eof;
  logic [SEL_W-1:0]  reg_sel, req, fwd_idx;
  logic              pin_mode, emit_idle, commit, path_evt, status_done;
  logic [NSRC:0]     force_fld;
  logic              force_on;
  logic [SEL_W:0]    force_pick;
  logic [DATA_W-1:0] nxt_data;
  logic [CTRL_W-1:0] nxt_ctrl;
  logic [NSRC-1:0]   nxt_en;

  for (genvar s = 0; s < NSRC; s++) begin : g_unpack
    assign w_data[s] = src_data[s*DATA_W +: DATA_W];
    assign w_ctrl[s] = src_ctrl[s*CTRL_W +: CTRL_W];
  end

  assign path_evt   = dp_reset | local_fault;
  assign req        = pin_mode ? sel_pins : reg_sel;
  assign force_on   = force_fld[NSRC];
  assign force_pick = lowest_en(force_fld[NSRC-1:0]);

  pktsw_frame_det u_det (
    .src_data (src_data),
    .src_ctrl (src_ctrl),
    .sof      (sof),
    .eof      (eof)
  );

  pktsw_smart #(.DEF_SEL(DEF_SEL)) u_smart (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .sof       (sof),
    .eof       (eof),
    .path_evt  (path_evt),
    .fwd_idx   (fwd_idx),
    .emit_idle (emit_idle),
    .commit    (commit)
  );

  pktsw_regs #(.DEF_SEL(DEF_SEL)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .path_evt    (path_evt),
    .commit      (commit),
    .en_now      (src_en),
    .reg_rdata   (reg_rdata),
    .reg_sel     (reg_sel),
    .pin_mode    (pin_mode),
    .force_fld   (force_fld),
    .status_done (status_done)
  );

  always_comb begin
    if (force_on) begin
      nxt_en = force_fld[NSRC-1:0];
      if (force_pick[SEL_W]) begin
        nxt_data = w_data[force_pick[SEL_W-1:0]];
        nxt_ctrl = w_ctrl[force_pick[SEL_W-1:0]];
      end else begin
        nxt_data = idle_data();
        nxt_ctrl = '1;
      end
    end else begin
      nxt_en = code_to_en(fwd_idx);
      if (emit_idle) begin
        nxt_data = idle_data();
        nxt_ctrl = '1;
      end else begin
        nxt_data = w_data[fwd_idx];
        nxt_ctrl = w_ctrl[fwd_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= idle_data();
      out_ctrl <= '1;
      src_en   <= code_to_en(DEF_SEL);
    end else begin
      out_data <= nxt_data;
      out_ctrl <= nxt_ctrl;
      src_en   <= nxt_en;
    end
  end
endmodule

// File: rtl/pktsw_chk.sv
module pktsw_chk
  import pktsw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              emit_idle,
  input logic              force_on,
  input logic [NSRC-1:0]   force_en,
  input logic              commit,
  input logic              path_evt,
  input logic              status_done,
  input logic [DATA_W-1:0] out_data,
  input logic [CTRL_W-1:0] out_ctrl,
  input logic [NSRC-1:0]   en_out
);
  // R4
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_idle && !force_on) |=> (out_ctrl == 8'hFF && out_data == {LANES{8'h07}}));

  // R7
  force_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> (en_out == $past(force_en)));

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> status_done);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !status_done) |=> !status_done);

  // R9
  evt_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_evt && !force_on) |=> (en_out == 4'b0001));

  // R2
  one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_on |=> ($countones(en_out) == 1));
endmodule

bind pktsw_top pktsw_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .emit_idle   (emit_idle),
  .force_on    (force_on),
  .force_en    (force_fld[3:0]),
  .commit      (commit),
  .path_evt    (path_evt),
  .status_done (status_done),
  .out_data    (out_data),
  .out_ctrl    (out_ctrl),
  .en_out      (src_en)
);

// File: tb/sim_pktsw_top.sv
module sim_pktsw_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [255:0]  src_data;
  logic [31:0]   src_ctrl;
  logic [1:0]    sel_pins;
  logic          dp_reset, local_fault, reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;
  logic [63:0]   out_data;
  logic [7:0]    out_ctrl;
  logic [3:0]    src_en;

  pktsw_top u0 (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_ctrl(src_ctrl),
    .sel_pins(sel_pins), .dp_reset(dp_reset), .local_fault(local_fault),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_data(out_data), .out_ctrl(out_ctrl), .src_en(src_en)
  );

  localparam logic [63:0] IDLE_W = 64'h0707070707070707;

  int tests = 0, fails = 0, cyc = 0;
  logic [1:0]  pins_v = 2'd0;
  logic [15:0] m_ctrl, m_force;
  logic        m_gap, m_open, m_done;
  logic [1:0]  m_act;
  logic [3:0]  m_en_last;
  logic        have_exp = 1'b0, rd_pend = 1'b0;
  logic [63:0] e_d;
  logic [7:0]  e_c;
  logic [3:0]  e_en;
  logic [15:0] e_rd;
  string       e_tag, e_rtag;

  // source s traffic: frame of 3+s words, period 6+2s, terminate in lane 4
  function automatic logic [71:0] gen(int s, int c);
    int len = 3 + s;
    int per = len + 3 + s;
    int ph = (c + 7 * s) % per;
    if (ph == 0)            return {8'h01, 8'(s), 24'(c), 24'h000000, 8'hFB};
    else if (ph < len - 1)  return {8'h00, 8'(s), 24'(c), 16'h5A5A, 16'(ph)};
    else if (ph == len - 1) return {8'hF0, 24'h070707, 8'hFD, 8'(s), 24'(c)};
    else                    return {8'hFF, IDLE_W};
  endfunction

  function automatic logic b_sof(logic [71:0] w);
    return w[64] && w[7:0] == 8'hFB;
  endfunction

  function automatic logic b_eof(logic [71:0] w);
    for (int l = 0; l < 8; l++) if (w[64+l] && w[8*l +: 8] == 8'hFD) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] wd,
                      input logic rd, input logic dpr, input logic lf, input string rtag);
    logic [71:0] w [4];
    logic [1:0]  rq;
    logic        ev, cm;
    string       tag;
    if (have_exp) begin
      tests++;
      if (out_data !== e_d || out_ctrl !== e_c || src_en !== e_en) begin
        fails++;
        $display("FAIL %s R10 cyc %0d: got d=%h c=%h en=%b expected d=%h c=%h en=%b",
                 e_tag, cyc, out_data, out_ctrl, src_en, e_d, e_c, e_en);
      end
    end
    if (rd_pend) begin
      tests++;
      if (reg_rdata !== e_rd) begin
        fails++;
        $display("FAIL %s read cyc %0d: got %h expected %h", e_rtag, cyc, reg_rdata, e_rd);
      end
      rd_pend = 1'b0;
    end
    for (int s = 0; s < 4; s++) begin
      w[s] = gen(s, cyc);
      src_data[s*64 +: 64] = w[s][63:0];
      src_ctrl[s*8 +: 8]   = w[s][71:64];
    end
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    dp_reset = dpr; local_fault = lf; sel_pins = pins_v;

    rq = m_ctrl[12] ? pins_v : m_ctrl[15:14];
    ev = dpr | lf;
    cm = 1'b0;
    if (ev) begin
      tag = "R9"; e_d = IDLE_W; e_c = 8'hFF; e_en = 4'b0001;
      m_gap = 1'b1; m_act = 2'd0; m_open = 1'b0;
    end else if (m_gap || (m_act != rq && !m_open)) begin
      tag = m_gap ? "R4" : "R5";
      if (b_sof(w[rq])) begin
        e_d = w[rq][63:0]; e_c = w[rq][71:64]; e_en = 4'b0001 << rq;
        m_act = rq; m_gap = 1'b0; m_open = !b_eof(w[rq]); cm = 1'b1;
      end else begin
        e_d = IDLE_W; e_c = 8'hFF; e_en = 4'b0001 << m_act; m_gap = 1'b1;
      end
    end else begin
      tag = (m_act != rq) ? "R3" : "R2";
      e_d = w[m_act][63:0]; e_c = w[m_act][71:64]; e_en = 4'b0001 << m_act;
      if (b_eof(w[m_act])) begin
        m_open = 1'b0;
        if (m_act != rq) m_gap = 1'b1;
      end else if (b_sof(w[m_act])) m_open = 1'b1;
    end
    if (m_force[4]) begin
      tag = "R7"; e_en = m_force[3:0]; e_d = IDLE_W; e_c = 8'hFF;
      for (int s = 3; s >= 0; s--) if (m_force[s]) begin e_d = w[s][63:0]; e_c = w[s][71:64]; end
    end
    if (rd) begin
      rd_pend = 1'b1; e_rtag = rtag;
      case (a)
        2'd0:    e_rd = m_ctrl;
        2'd1:    e_rd = m_force;
        2'd2:    e_rd = {m_en_last, 1'b0, m_done, 10'h000};
        default: e_rd = 16'h0000;
      endcase
    end
    m_done = cm | (m_done & !(rd && a == 2'd2));
    m_en_last = e_en;
    if (ev) m_ctrl[15:14] = 2'b00;
    else if (wr && a == 2'd0) m_ctrl = wd;
    if (wr && a == 2'd1) m_force = wd;
    have_exp = 1'b1; e_tag = tag;
    @(negedge clk);
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic rreg(input logic [1:0] a, input string tag);
    step(1'b0, a, 16'h0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R10: got hung run expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_data = {4{IDLE_W}}; src_ctrl = '1; sel_pins = 2'd0;
    dp_reset = 1'b0; local_fault = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = 2'd0; reg_wdata = 16'h0;
    m_ctrl = 16'h1000; m_force = 16'h0; m_gap = 1'b1; m_act = 2'd0;
    m_open = 1'b0; m_done = 1'b0; m_en_last = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tests++;
    if (out_data !== IDLE_W || out_ctrl !== 8'hFF || src_en !== 4'b0001) begin
      fails++;
      $display("FAIL R1 reset: got d=%h c=%h en=%b expected d=%h c=ff en=0001",
               out_data, out_ctrl, src_en, IDLE_W);
    end
    rreg(2'd2, "R1");
    rreg(2'd0, "R1");
    run(20);
    rreg(2'd2, "R8");
    rreg(2'd2, "R8");
    wreg(2'd0, 16'h0000);
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        wreg(2'd0, {2'(o), 14'h0});
        run(25 + o + n);
        wreg(2'd0, {2'(n), 14'h0});
        rreg(2'd2, "R6");
        run(30);
        rreg(2'd2, "R8");
      end
    end
    // R6: retarget while pending
    wreg(2'd0, 16'h4000); run(1); wreg(2'd0, 16'hC000); run(1);
    rreg(2'd2, "R6"); run(40); rreg(2'd2, "R8"); rreg(2'd2, "R8");
    // R2: pin select
    wreg(2'd0, 16'h1000);
    pins_v = 2'd3; run(30);
    pins_v = 2'd1; run(30);
    pins_v = 2'd0; run(30);
    rreg(2'd0, "R2");
    // R7: force
    wreg(2'd1, 16'h0014); run(10);
    wreg(2'd1, 16'h0013); run(10);
    wreg(2'd1, 16'h0010); run(5);
    rreg(2'd1, "R7");
    wreg(2'd1, 16'h0000); run(30);
    // R9: data-path reset and local fault
    wreg(2'd0, 16'h8000); run(30);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, "");
    run(3);
    rreg(2'd0, "R9");
    run(30);
    wreg(2'd0, 16'hC000); run(20);
    wreg(2'd1, 16'h0018); run(3);
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1, "");
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1, "");
    run(5);
    rreg(2'd1, "R9");
    rreg(2'd0, "R9");
    wreg(2'd1, 16'h0000); run(40);
    rreg(2'd2, "R8");
    run(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule